// File: doc/BRIEF.md
# Signalling Burst CRC Checker

This block decides whether a single-block signalling burst arrived intact. It takes a 96-bit payload that has already been deinterleaved and corrected by the block code. A 4-bit burst-type code tells it which 16-bit mask covers the trailing CRC. The block runs a CRC-CCITT over the leading 80 message bits, one bit per clock. It then compares that result with the received CRC after the received CRC has been XORed with the mask.

A tolerance rule handles systems that deliberately corrupt the CRC. When the rule is enabled, a CRC failure is reported downstream as valid if three things hold: the reserved field carries the code 4, the FEC stage saw no irrecoverable error, and message byte 1 is not 0x68. The true comparison result is kept on its own output.

One payload is accepted per start strobe. The inputs are captured on that edge. The results stay on the outputs until the next start that is accepted.

The controller has three states:
- IDLE waits for start.
- SHIFT feeds the 80 message bits through the CRC engine.
- JUDGE registers the verdict and raises done.

Transitions:
- start-check: IDLE to SHIFT, for a type that carries a CRC.
- start-skip: IDLE to JUDGE, for a continuation or unsupported type.
- start-ignore: IDLE to IDLE, for the idle type.
- last-bit: SHIFT to JUDGE, after the 80th bit.
- report: JUDGE to IDLE.

Top module: `burst_crc_check`

## Requirements
- R1: After reset, done, crc_ok, crc_ok_raw and ras are all low.
- R2: The mask is chosen by burst_type: 0x0 gives 0x6969, 0x3 gives 0xA5A5, 0x4 gives 0xAAAA, 0x6 gives 0xCCCC, and 0xB gives 0x3333.
- R3: The CRC uses polynomial 0x1021 and starts from zero. It runs over payload[95:16] with payload[95] first. crc_ok_raw is high exactly when the result equals payload[15:0] XOR the mask.
- R4: For a checked type, done is low on the cycle after the accepting edge. done rises on the 81st rising edge after that edge. The result is held until the next accepted start.
- R5: ras is high exactly when all of these hold: ras_enable is high, the CRC check failed, fec_err is low, reserved equals 3'b100 (bit 2 set, bits 1 and 0 clear), and R6 does not block it.
- R6: ras stays low when payload[87:80] (message byte 1) equals 0x68.
- R7: crc_ok equals crc_ok_raw OR ras.
- R8: For type 0x5, and for any type not named in R2 or R9, done rises on the first edge after acceptance and all three flags are low.
- R9: A start with type 0x9 is ignored. done and all flags keep their previous values, and no run begins.
- R10: A start that arrives while a run is in progress is ignored. The running check completes on the data it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept one payload (only while idle) |
| burst_type | input | 4 | Burst-type code |
| payload | input | 96 | Corrected payload; bit 95 is the first message bit |
| reserved | input | 3 | Reserved field, R0 in bit 0 |
| fec_err | input | 1 | FEC reported irrecoverable errors |
| ras_enable | input | 1 | Enables the tolerance rule |
| done | output | 1 | Result valid, held |
| crc_ok | output | 1 | CRC verdict passed downstream |
| crc_ok_raw | output | 1 | True CRC comparison result |
| ras | output | 1 | Tolerance override applied |

## Verification
Random payloads go through every checked type. Each payload either carries a correctly masked CRC or a corrupted one, so a mask swapped between types or a wrong bit order shows up as a raw mismatch.

The reserved field, fec_err, ras_enable and byte 1 are biased toward the override code and toward 0x68. This covers every term of the tolerance rule in both polarities, so a dropped term is caught.

Directed runs cover the reset state and the continuation, unsupported and idle types. They also check a start issued mid-run, which tells a clean restart apart from a correctly ignored request. Latency is measured on every run.

// File: rtl/burst_crc_pkg.sv
package burst_crc_pkg;

    typedef enum logic [1:0] {
        CLS_CHECK  = 2'd0,
        CLS_SKIP   = 2'd1,
        CLS_IGNORE = 2'd2
    } burst_class_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_JUDGE = 2'd2
    } chk_state_e;

    localparam logic [3:0] BT_PRIV   = 4'h0;
    localparam logic [3:0] BT_CTRL   = 4'h3;
    localparam logic [3:0] BT_MHDR   = 4'h4;
    localparam logic [3:0] BT_MCONT  = 4'h5;
    localparam logic [3:0] BT_DHDR   = 4'h6;
    localparam logic [3:0] BT_IDLE   = 4'h9;
    localparam logic [3:0] BT_SINGLE = 4'hB;

endpackage

// File: rtl/burst_mask_lut.sv
module burst_mask_lut
    import burst_crc_pkg::*;
#(
    parameter int TYPE_W = 4,
    parameter int CRC_W  = 16
) (
    input  logic [TYPE_W-1:0] burst_type,
    output logic [CRC_W-1:0]  mask,
    output burst_class_e      cls
);

    localparam logic [15:0] M_PRIV   = 16'h6969;
    localparam logic [15:0] M_CTRL   = 16'hA5A5;
    localparam logic [15:0] M_MHDR   = 16'hAAAA;
    localparam logic [15:0] M_DHDR   = 16'hCCCC;
    localparam logic [15:0] M_SINGLE = 16'h3333;

    always_comb begin
        mask = '0;
        cls  = CLS_SKIP;
        unique case (burst_type)
            BT_PRIV:   begin mask = CRC_W'(M_PRIV);   cls = CLS_CHECK;  end
            BT_CTRL:   begin mask = CRC_W'(M_CTRL);   cls = CLS_CHECK;  end
            BT_MHDR:   begin mask = CRC_W'(M_MHDR);   cls = CLS_CHECK;  end
            BT_DHDR:   begin mask = CRC_W'(M_DHDR);   cls = CLS_CHECK;  end
            BT_SINGLE: begin mask = CRC_W'(M_SINGLE); cls = CLS_CHECK;  end
            BT_IDLE:   begin cls = CLS_IGNORE; end
            default:   begin cls = CLS_SKIP;   end
        endcase
    end

endmodule

// File: rtl/crc16_serial.sv
module crc16_serial #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_step;
    logic             fb;

    always_comb begin
        fb       = crc_q[CRC_W-1] ^ bit_in;
        crc_step = {crc_q[CRC_W-2:0], 1'b0};
        if (fb) crc_step = crc_step ^ CRC_W'(POLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        crc_q <= '0;
        else if (clear)    crc_q <= '0;
        else if (shift_en) crc_q <= crc_step;
    end

    assign crc = crc_q;

    assert_crc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !shift_en) |=> $stable(crc_q));

    assert_crc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc_q == '0));

endmodule

// File: rtl/burst_verdict.sv
module burst_verdict #(
    parameter int          CRC_W     = 16,
    parameter int          RES_W     = 3,
    parameter logic [2:0]  RAS_CODE  = 3'b100,
    parameter logic [7:0]  VETO_BYTE = 8'h68
) (
    input  logic [CRC_W-1:0] crc_calc,
    input  logic [CRC_W-1:0] crc_rx,
    input  logic [CRC_W-1:0] mask,
    input  logic [RES_W-1:0] reserved,
    input  logic [7:0]       byte1,
    input  logic             fec_err,
    input  logic             ras_enable,
    output logic             raw_ok,
    output logic             ras,
    output logic             ok
);

    logic res_match;
    logic vetoed;

    always_comb begin
        raw_ok    = (crc_calc == (crc_rx ^ mask));
        res_match = (reserved == RES_W'(RAS_CODE));
        vetoed    = (byte1 == VETO_BYTE);
        ras       = ras_enable && !raw_ok && !fec_err && res_match && !vetoed;
        ok        = raw_ok || ras;
    end

endmodule

// File: rtl/burst_crc_check.sv
module burst_crc_check
    import burst_crc_pkg::*;
#(
    parameter int DATA_W = 96,
    parameter int CRC_W  = 16,
    parameter int TYPE_W = 4,
    parameter int RES_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TYPE_W-1:0] burst_type,
    input  logic [DATA_W-1:0] payload,
    input  logic [RES_W-1:0]  reserved,
    input  logic              fec_err,
    input  logic              ras_enable,
    output logic              done,
    output logic              crc_ok,
    output logic              crc_ok_raw,
    output logic              ras
);

    localparam int MSG_W = DATA_W - CRC_W;
    localparam int CNT_W = $clog2(MSG_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MSG_W - 1);
    localparam int B1_HI = DATA_W - 9;

    chk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [MSG_W-1:0] msg_q;
    logic [CRC_W-1:0] rx_crc_q, mask_q;
    logic [RES_W-1:0] res_q;
    logic [7:0]       byte1_q;
    logic             fec_q, en_q, skip_q;

    logic [CRC_W-1:0] lut_mask;
    burst_class_e     lut_cls;
    logic [CRC_W-1:0] crc_val;
    logic             v_raw, v_ras, v_ok;
    logic             accept, shifting;

    burst_mask_lut #(.TYPE_W(TYPE_W), .CRC_W(CRC_W)) lut_i (
        .burst_type (burst_type),
        .mask       (lut_mask),
        .cls        (lut_cls)
    );

    assign accept   = (state_q == S_IDLE) && start && (lut_cls != CLS_IGNORE);
    assign shifting = (state_q == S_SHIFT);

    crc16_serial #(.CRC_W(CRC_W), .POLY(16'h1021)) crc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .shift_en (shifting),
        .bit_in   (msg_q[MSG_W-1]),
        .crc      (crc_val)
    );

    burst_verdict #(.CRC_W(CRC_W), .RES_W(RES_W)) verdict_i (
        .crc_calc   (crc_val),
        .crc_rx     (rx_crc_q),
        .mask       (mask_q),
        .reserved   (res_q),
        .byte1      (byte1_q),
        .fec_err    (fec_q),
        .ras_enable (en_q),
        .raw_ok     (v_raw),
        .ras        (v_ras),
        .ok         (v_ok)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) state_d = (lut_cls == CLS_CHECK) ? S_SHIFT : S_JUDGE;
            end
            S_SHIFT: begin
                if (cnt_q == LAST) state_d = S_JUDGE;
            end
            S_JUDGE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // capture and message shift
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            msg_q    <= '0;
            rx_crc_q <= '0;
            mask_q   <= '0;
            res_q    <= '0;
            byte1_q  <= '0;
            fec_q    <= 1'b0;
            en_q     <= 1'b0;
            skip_q   <= 1'b0;
        end else if (accept) begin
            cnt_q    <= '0;
            msg_q    <= payload[DATA_W-1:CRC_W];
            rx_crc_q <= payload[CRC_W-1:0];
            mask_q   <= lut_mask;
            res_q    <= reserved;
            byte1_q  <= payload[B1_HI -: 8];
            fec_q    <= fec_err;
            en_q     <= ras_enable;
            skip_q   <= (lut_cls == CLS_SKIP);
        end else if (shifting) begin
            cnt_q <= cnt_q + 1'b1;
            msg_q <= {msg_q[MSG_W-2:0], 1'b0};
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            crc_ok     <= 1'b0;
            crc_ok_raw <= 1'b0;
            ras        <= 1'b0;
        end else if (accept) begin
            done       <= 1'b0;
            crc_ok     <= 1'b0;
            crc_ok_raw <= 1'b0;
            ras        <= 1'b0;
        end else if (state_q == S_JUDGE) begin
            done       <= 1'b1;
            crc_ok     <= skip_q ? 1'b0 : v_ok;
            crc_ok_raw <= skip_q ? 1'b0 : v_raw;
            ras        <= skip_q ? 1'b0 : v_ras;
        end
    end

    assert_ok_covers_ras_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ras |-> crc_ok);

    assert_ras_only_on_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ras |-> !crc_ok_raw);

    assert_done_after_judge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state_q) == S_JUDGE));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SHIFT) |-> (cnt_q <= LAST));

    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SHIFT && start) |=> ($stable(rx_crc_q) && $stable(mask_q)));

    assert_idle_type_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && lut_cls == CLS_IGNORE)
            |=> ($stable(done) && $stable(crc_ok) && state_q == S_IDLE));

endmodule

// File: tb/burst_crc_check_tb_top.sv
module burst_crc_check_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  burst_type = '0;
    logic [95:0] payload = '0;
    logic [2:0]  reserved = '0;
    logic        fec_err = 1'b0;
    logic        ras_enable = 1'b0;
    logic        done, crc_ok, crc_ok_raw, ras;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    burst_crc_check dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .burst_type(burst_type),
        .payload(payload), .reserved(reserved), .fec_err(fec_err),
        .ras_enable(ras_enable), .done(done), .crc_ok(crc_ok),
        .crc_ok_raw(crc_ok_raw), .ras(ras)
    );

    function automatic logic [15:0] ref_mask(input logic [3:0] t);
        case (t)
            4'h0: return 16'h6969;
            4'h3: return 16'hA5A5;
            4'h4: return 16'hAAAA;
            4'h6: return 16'hCCCC;
            4'hB: return 16'h3333;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic bit is_checked(input logic [3:0] t);
        return (t == 4'h0 || t == 4'h3 || t == 4'h4 || t == 4'h6 || t == 4'hB);
    endfunction

    function automatic logic [15:0] ref_crc(input logic [95:0] p);
        logic [15:0] c = '0;
        for (int i = 95; i >= 16; i--) begin
            logic fb = c[15] ^ p[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // issue one accepted burst and check its result
    task automatic run(input logic [3:0] t, input logic [95:0] p, input logic [2:0] r,
                       input logic fe, input logic en);
        int  lat;
        bit  exp_raw, exp_ras, chk;
        chk = is_checked(t);
        @(negedge clk);
        burst_type = t; payload = p; reserved = r; fec_err = fe; ras_enable = en;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        payload = ~p;
        lat = 1;
        check("R4 done low after accept", 32'(done), 32'd0);
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        if (chk) begin
            exp_raw = (ref_crc(p) == (p[15:0] ^ ref_mask(t)));
            exp_ras = en && !exp_raw && !fe && (r == 3'b100) && (p[87:80] != 8'h68);
            check("R4 latency", 32'(lat), 32'd82);
            check("R3 crc_ok_raw", 32'(crc_ok_raw), 32'(exp_raw));
            check("R5 R6 ras", 32'(ras), 32'(exp_ras));
            check("R7 crc_ok", 32'(crc_ok), 32'(exp_raw | exp_ras));
        end else begin
            check("R8 latency", 32'(lat), 32'd2);
            check("R8 flags", {29'd0, crc_ok, crc_ok_raw, ras}, 32'd0);
        end
    endtask

    function automatic logic [95:0] good_payload(input logic [3:0] t, input logic [95:0] p);
        logic [95:0] q = p;
        q[15:0] = ref_crc(p) ^ ref_mask(t);
        return q;
    endfunction

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] types [5];
        logic [95:0] p;
        types = '{4'h0, 4'h3, 4'h4, 4'h6, 4'hB};
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset flags", {28'd0, done, crc_ok, crc_ok_raw, ras}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {28'd0, done, crc_ok, crc_ok_raw, ras}, 32'd0);

        // R2 R3 every checked type, good and corrupted CRC
        foreach (types[k]) begin
            p = {$urandom(), $urandom(), $urandom()};
            run(types[k], good_payload(types[k], p), 3'b000, 1'b0, 1'b0);
            check("R2 good masked crc", 32'(crc_ok_raw), 32'd1);
            run(types[k], good_payload(types[k], p) ^ 96'h1, 3'b000, 1'b0, 1'b0);
            check("R3 corrupted crc", 32'(crc_ok_raw), 32'd0);
        end
        // R2 wrong mask: 0x3 payload checked as 0x4
        p = good_payload(4'h3, 96'h0123_4567_89AB_CDEF_0011_2233);
        p[87:80] = 8'h11;
        p = good_payload(4'h3, p);
        run(4'h4, p, 3'b000, 1'b0, 1'b0);
        check("R2 mask differs by type", 32'(crc_ok_raw), 32'd0);

        // R5 override and each blocking term
        p = {$urandom(), $urandom(), $urandom()};
        p[87:80] = 8'h12;
        p = good_payload(4'h6, p) ^ 96'h4;
        run(4'h6, p, 3'b100, 1'b0, 1'b1);
        check("R5 override raises ras", 32'(ras), 32'd1);
        check("R7 override passes ok", 32'(crc_ok), 32'd1);
        run(4'h6, p, 3'b100, 1'b0, 1'b0);
        check("R5 disabled", 32'(ras), 32'd0);
        run(4'h6, p, 3'b100, 1'b1, 1'b1);
        check("R5 fec error blocks", 32'(ras), 32'd0);
        run(4'h6, p, 3'b101, 1'b0, 1'b1);
        check("R5 reserved code", 32'(ras), 32'd0);
        run(4'h6, good_payload(4'h6, p), 3'b100, 1'b0, 1'b1);
        check("R5 no ras on good crc", 32'(ras), 32'd0);
        p[87:80] = 8'h68;
        run(4'h6, p, 3'b100, 1'b0, 1'b1);
        check("R6 byte1 veto", 32'(ras), 32'd0);
        check("R6 veto keeps fail", 32'(crc_ok), 32'd0);

        // R8 continuation and unsupported
        run(4'h5, p, 3'b100, 1'b0, 1'b1);
        run(4'h1, good_payload(4'h0, p), 3'b000, 1'b0, 1'b0);
        run(4'hF, p, 3'b100, 1'b0, 1'b1);

        // R9 idle type ignored: set known result first
        run(4'h0, good_payload(4'h0, p), 3'b000, 1'b0, 1'b0);
        @(negedge clk);
        burst_type = 4'h9; payload = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 idle keeps done", 32'(done), 32'd1);
        check("R9 idle keeps crc_ok", 32'(crc_ok), 32'd1);
        check("R9 idle keeps raw", 32'(crc_ok_raw), 32'd1);

        // R10 start during a run
        p = good_payload(4'h3, {$urandom(), $urandom(), $urandom()});
        @(negedge clk);
        burst_type = 4'h3; payload = p; reserved = 3'b000; ras_enable = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        burst_type = 4'h0; payload = ~p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (70) @(negedge clk);
        check("R10 busy start ignored, done", 32'(done), 32'd1);
        check("R10 first run result", 32'(crc_ok_raw), 32'd1);

        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [3:0]  t;
            logic [2:0]  r;
            logic [31:0] sel;
            sel = $urandom();
            t = (sel[3:0] < 4'd12) ? types[sel[3:0] % 5] : sel[7:4];
            if (t == 4'h9) t = 4'h5;
            p = {$urandom(), $urandom(), $urandom()};
            if (sel[8]) p[87:80] = 8'h68;
            if (sel[10:9] != 2'b00) p = good_payload(t, p);
            if (sel[11]) p[15:0] = p[15:0] ^ 16'(sel[31:16] | 16'h1);
            r = sel[12] ? 3'b100 : 3'($urandom());
            run(t, p, r, sel[13] & sel[14], sel[15]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule